// File: doc/BRIEF.md
# Flash status and write-protect controller

This block keeps the status byte of a serial flash device and decides which state-changing commands may run. A front end that has already framed and decoded each command (so a command is presented only once its chip-select window has closed) hands it over as one valid cycle with a command code, an address and a data byte. The controller keeps the write-enable latch, the three-bit protection level and the lock bit. It checks every program or erase request against the protected region. For each accepted operation it runs a busy window of a set number of cycles. A one-cycle start pulse with the aligned target address tells the array engine to begin.

The protection level names how many of the highest 64 KB blocks are guarded. The count doubles with each step of the level, and the highest level guards the whole array. The lock bit, together with the write-protect input, decides whether the status byte may be rewritten at all. The durations of the operations are parameters, kept short so that simulation stays fast.

Top module: `flash_status_ctrl`

## Requirements
- R1: After reset the status byte reads 0x1C: protection level 111, lock bit 0, write-enable latch 0, busy 0. Its layout is busy at bit 0, write-enable latch at bit 1, protection level at bits 4:2, lock bit at bit 7.
- R2: Command code 1 sets the write-enable latch and command code 2 clears it. Each takes effect on the clock edge at which it is presented.
- R3: Command code 3 arms a one-shot permission. The very next valid command, of any code, consumes it. That command may then be a status write (code 4) even though the write-enable latch is 0.
- R4: A status write (code 4) is accepted only when the latch is 1 or the one-shot is armed, and also when write_prot_n is 1 or the lock bit is 0. When accepted, data bits 4:2 become the protection level and data bit 7 becomes the lock bit. A rejected write changes nothing.
- R5: A program (code 6), sector erase (code 7), block erase (code 8) or chip erase (code 9) is ignored while the write-enable latch is 0. An ignored request gives no start pulse and does not set busy.
- R6: A nonzero protection level L guards the highest min(2^(L-1), 64) blocks of 64 KB. The block number is address bits 21:16. A program, sector erase or block erase aimed at a guarded block is ignored and does not set busy.
- R7: A chip erase is accepted only when the protection level is 000.
- R8: An accepted operation holds busy at 1 for exactly its set number of cycles: 6 for a program, 10 for a sector erase, 14 for a block erase, 20 for a chip erase and 4 for a status write. The write-enable latch clears in the cycle busy falls.
- R9: While busy is 1, every command except the status read is ignored. This includes a command that arrives in the last busy cycle.
- R10: A status read (code 5) returns, one cycle later on rd_valid_o and rd_data_o, the status byte as it was when the read was presented. A read is honoured while busy.
- R11: An accepted array operation raises start_o for one cycle, carrying its command code and target address. A program keeps the full address. A sector erase is aligned down to 4 KB and a block erase to 64 KB. A chip erase reports address 0.
- R12: Status bits 6 and 5 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A decoded command is presented this cycle |
| cmd_op | input | 4 | Command code (see requirements) |
| cmd_addr | input | 22 | Byte address for program and erase |
| cmd_wdata | input | 8 | Data byte for a status write |
| write_prot_n | input | 1 | Write-protect input, active low |
| status_o | output | 8 | Current status byte |
| busy_o | output | 1 | Operation in progress |
| rd_valid_o | output | 1 | Status-read result valid |
| rd_data_o | output | 8 | Status-read result |
| start_o | output | 1 | Start pulse to the array engine |
| start_op_o | output | 4 | Command code of the started operation |
| start_addr_o | output | 22 | Aligned target address of the started operation |

## Verification
A new command and the end of a busy window can meet in the same cycle. Busy is still 1 there, so the command must be ignored, and the write-enable latch must clear in that cycle. The bench counts an accepted chip erase down to its final busy cycle and presents a latch-set command exactly there. It then expects the latch at 0 and no new busy window. Random traffic also lands many commands on completion cycles. In every cycle, all outputs are compared with a bench model built from the requirements.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;

  typedef enum logic [3:0] {
    OP_NOP      = 4'd0,
    OP_WREN     = 4'd1,
    OP_WRDI     = 4'd2,
    OP_ARM      = 4'd3,
    OP_WRSR     = 4'd4,
    OP_RDSR     = 4'd5,
    OP_PROG     = 4'd6,
    OP_ERASE_S  = 4'd7,
    OP_ERASE_B  = 4'd8,
    OP_ERASE_C  = 4'd9
  } op_t;

  localparam int SR_BUSY = 0;
  localparam int SR_WEL  = 1;
  localparam int SR_BPLO = 2;
  localparam int SR_LOCK = 7;

endpackage

// File: rtl/fsw_region_guard.sv
module fsw_region_guard
  import flash_stat_pkg::*;
#(
  parameter int NUM_BLOCKS   = 64,
  parameter int BLOCK_BYTES  = 65536,
  parameter int SECTOR_BYTES = 4096,
  parameter int AW           = 22
) (
  input  op_t           op,
  input  logic [2:0]    bp,
  input  logic [AW-1:0] addr,
  output logic          allow,
  output logic [AW-1:0] base
);
  localparam int BLK_SH = $clog2(BLOCK_BYTES);
  localparam int SEC_SH = $clog2(SECTOR_BYTES);
  localparam int BW     = AW - BLK_SH;

  logic [BW:0] thr [8];
  logic [BW:0] blk;
  logic        hit;

  // threshold block number per protection level
  for (genvar g = 0; g < 8; g++) begin : g_thr
    localparam int RAW = (g == 0) ? 0 : (1 << (g - 1));
    localparam int N   = (RAW > NUM_BLOCKS) ? NUM_BLOCKS : RAW;
    assign thr[g] = (BW+1)'(NUM_BLOCKS - N);
  end

  assign blk = {1'b0, addr[AW-1:BLK_SH]};
  assign hit = (blk >= thr[bp]);

  always_comb begin
    case (op)
      OP_PROG, OP_ERASE_S, OP_ERASE_B: allow = !hit;
      OP_ERASE_C:                      allow = (bp == 3'b000);
      default:                         allow = 1'b0;
    endcase
  end

  always_comb begin
    case (op)
      OP_ERASE_S: base = {addr[AW-1:SEC_SH], {SEC_SH{1'b0}}};
      OP_ERASE_B: base = {addr[AW-1:BLK_SH], {BLK_SH{1'b0}}};
      OP_ERASE_C: base = '0;
      default:    base = addr;
    endcase
  end
endmodule

// File: rtl/fsw_busy_timer.sv
module fsw_busy_timer #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_len,
  output logic          busy,
  output logic          done
);
  logic [CW-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (load) begin
      busy <= 1'b1;
      cnt  <= load_len - CW'(1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - CW'(1);
    end
  end
endmodule

// File: rtl/fsw_status_regs.sv
module fsw_status_regs (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_seen,
  input  logic       wel_set,
  input  logic       wel_clr,
  input  logic       op_end,
  input  logic       arm_set,
  input  logic       sr_load,
  input  logic [2:0] new_bp,
  input  logic       new_lock,
  output logic       wel,
  output logic       arm,
  output logic [2:0] bp,
  output logic       lock
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wel  <= 1'b0;
      arm  <= 1'b0;
      bp   <= 3'b111;
      lock <= 1'b0;
    end else begin
      if (wel_set)               wel <= 1'b1;
      else if (wel_clr || op_end) wel <= 1'b0;

      if (arm_set)       arm <= 1'b1;
      else if (cmd_seen) arm <= 1'b0;

      if (sr_load) begin
        bp   <= new_bp;
        lock <= new_lock;
      end
    end
  end
endmodule

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl
  import flash_stat_pkg::*;
#(
  parameter int NUM_BLOCKS   = 64,
  parameter int BLOCK_BYTES  = 65536,
  parameter int SECTOR_BYTES = 4096,
  parameter int T_PROG       = 6,
  parameter int T_SEC        = 10,
  parameter int T_BLK        = 14,
  parameter int T_CHIP       = 20,
  parameter int T_WRSR       = 4,
  localparam int AW          = $clog2(NUM_BLOCKS * BLOCK_BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [3:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [7:0]    cmd_wdata,
  input  logic          write_prot_n,
  output logic [7:0]    status_o,
  output logic          busy_o,
  output logic          rd_valid_o,
  output logic [7:0]    rd_data_o,
  output logic          start_o,
  output logic [3:0]    start_op_o,
  output logic [AW-1:0] start_addr_o
);
  localparam int M1    = (T_PROG > T_SEC) ? T_PROG : T_SEC;
  localparam int M2    = (T_BLK > T_CHIP) ? T_BLK : T_CHIP;
  localparam int M3    = (M1 > M2) ? M1 : M2;
  localparam int T_MAX = (M3 > T_WRSR) ? M3 : T_WRSR;
  localparam int CW    = $clog2(T_MAX + 1);

  op_t           op;
  logic          busy, done, wel, arm, lock;
  logic [2:0]    bp;
  logic          free_cmd, wrsr_ok, arr_ok, guard_ok, load;
  logic [CW-1:0] len;
  logic [AW-1:0] base;
  logic          unused_wdata;

  assign op           = op_t'(cmd_op);
  assign unused_wdata = ^{cmd_wdata[6:5], cmd_wdata[1:0]};
  assign free_cmd     = cmd_valid && !busy;

  fsw_region_guard #(
    .NUM_BLOCKS(NUM_BLOCKS), .BLOCK_BYTES(BLOCK_BYTES),
    .SECTOR_BYTES(SECTOR_BYTES), .AW(AW)
  ) u_guard (
    .op(op), .bp(bp), .addr(cmd_addr), .allow(guard_ok), .base(base)
  );

  assign wrsr_ok = free_cmd && (op == OP_WRSR) && (wel || arm) &&
                   (write_prot_n || !lock);
  assign arr_ok  = free_cmd && wel && guard_ok;
  assign load    = wrsr_ok || arr_ok;

  always_comb begin
    case (op)
      OP_PROG:    len = CW'(T_PROG);
      OP_ERASE_S: len = CW'(T_SEC);
      OP_ERASE_B: len = CW'(T_BLK);
      OP_ERASE_C: len = CW'(T_CHIP);
      default:    len = CW'(T_WRSR);
    endcase
  end

  fsw_busy_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .load(load), .load_len(len),
    .busy(busy), .done(done)
  );

  fsw_status_regs u_regs (
    .clk(clk), .rst(rst),
    .cmd_seen(cmd_valid),
    .wel_set(free_cmd && (op == OP_WREN)),
    .wel_clr(free_cmd && (op == OP_WRDI)),
    .op_end(done),
    .arm_set(free_cmd && (op == OP_ARM)),
    .sr_load(wrsr_ok),
    .new_bp(cmd_wdata[4:2]),
    .new_lock(cmd_wdata[7]),
    .wel(wel), .arm(arm), .bp(bp), .lock(lock)
  );

  assign busy_o   = busy;
  assign status_o = {lock, 2'b00, bp, wel, busy};

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_o   <= 1'b0;
      rd_data_o    <= '0;
      start_o      <= 1'b0;
      start_op_o   <= '0;
      start_addr_o <= '0;
    end else begin
      rd_valid_o <= cmd_valid && (op == OP_RDSR);
      if (cmd_valid && (op == OP_RDSR)) rd_data_o <= status_o;
      start_o <= arr_ok;
      if (arr_ok) begin
        start_op_o   <= cmd_op;
        start_addr_o <= base;
      end
    end
  end
endmodule

// File: rtl/flash_status_ctrl_chk.sv
module flash_status_ctrl_chk
  import flash_stat_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic [3:0] cmd_op,
  input logic [7:0] status_o,
  input logic       busy_o,
  input logic       rd_valid_o,
  input logic [7:0] rd_data_o,
  input logic       start_o,
  input logic [3:0] start_op_o
);
  a_r12_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    status_o[6:5] == 2'b00);

  a_r5_start_needs_wel: assert property (@(posedge clk) disable iff (rst)
    start_o |-> $past(status_o[SR_WEL]));

  a_r9_start_only_when_idle: assert property (@(posedge clk) disable iff (rst)
    start_o |-> !$past(busy_o));

  a_r8_start_sets_busy: assert property (@(posedge clk) disable iff (rst)
    start_o |-> busy_o);

  a_r8_wel_clear_at_end: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> !status_o[SR_WEL]);

  a_r7_chip_needs_open: assert property (@(posedge clk) disable iff (rst)
    (start_o && start_op_o == 4'(OP_ERASE_C)) |-> ($past(status_o[4:2]) == 3'b000));

  a_r10_read_returns_prior: assert property (@(posedge clk) disable iff (rst)
    rd_valid_o |-> (rd_data_o == $past(status_o)));

  a_r2_wel_rise_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(status_o[SR_WEL]) |-> $past(cmd_valid && cmd_op == 4'(OP_WREN) && !busy_o));

  a_r4_prot_change_cause: assert property (@(posedge clk) disable iff (rst)
    (status_o[7:2] != $past(status_o[7:2])) |-> $past(cmd_valid && cmd_op == 4'(OP_WRSR)));
endmodule

bind flash_status_ctrl flash_status_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .status_o(status_o), .busy_o(busy_o), .rd_valid_o(rd_valid_o),
  .rd_data_o(rd_data_o), .start_o(start_o), .start_op_o(start_op_o)
);

// File: tb/flash_status_ctrl_bench.sv
module flash_status_ctrl_bench;
  localparam int AW = 22;
  localparam int TP = 6, TS = 10, TB = 14, TC = 20, TW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [3:0]    cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [7:0]    cmd_wdata = '0;
  logic          write_prot_n = 1'b1;
  logic [7:0]    status_o, rd_data_o;
  logic          busy_o, rd_valid_o, start_o;
  logic [3:0]    start_op_o;
  logic [AW-1:0] start_addr_o;

  always #4 clk = ~clk;

  flash_status_ctrl #(
    .T_PROG(TP), .T_SEC(TS), .T_BLK(TB), .T_CHIP(TC), .T_WRSR(TW)
  ) u_flash_status_ctrl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .write_prot_n(write_prot_n),
    .status_o(status_o), .busy_o(busy_o), .rd_valid_o(rd_valid_o),
    .rd_data_o(rd_data_o), .start_o(start_o), .start_op_o(start_op_o),
    .start_addr_o(start_addr_o)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // bench model state
  logic       m_busy = 0, m_wel = 0, m_arm = 0, m_lock = 0;
  logic [2:0] m_bp = 3'b111;
  int         m_cnt = 0;
  logic [7:0] e_rd;
  logic       e_rdv, e_start;
  logic [3:0] e_op;
  logic [AW-1:0] e_addr;

  function automatic logic [7:0] m_status();
    return {m_lock, 2'b00, m_bp, m_wel, m_busy};
  endfunction

  function automatic bit guarded(logic [2:0] bp, logic [AW-1:0] a);
    int n;
    if (bp == 0) return 0;
    n = 1 << (bp - 1);
    if (n > 64) n = 64;
    return int'(a[21:16]) >= 64 - n;
  endfunction

  function automatic int dur(logic [3:0] op);
    case (op)
      4'd6: return TP;
      4'd7: return TS;
      4'd8: return TB;
      4'd9: return TC;
      default: return TW;
    endcase
  endfunction

  function automatic logic [AW-1:0] align(logic [3:0] op, logic [AW-1:0] a);
    case (op)
      4'd7: return {a[21:12], 12'h000};
      4'd8: return {a[21:16], 16'h0000};
      4'd9: return '0;
      default: return a;
    endcase
  endfunction

  task automatic model_step(logic v, logic [3:0] op, logic [AW-1:0] a,
                            logic [7:0] d, logic wp);
    logic arm_old;
    bit ok;
    e_rdv = v && op == 4'd5;
    if (e_rdv) e_rd = m_status();
    e_start = 0;
    arm_old = m_arm;
    if (v) m_arm = 0;
    if (m_busy) begin
      if (m_cnt == 0) begin m_busy = 0; m_wel = 0; end
      else m_cnt--;
    end else if (v) begin
      ok = 0;
      case (op)
        4'd1: m_wel = 1;
        4'd2: m_wel = 0;
        4'd3: m_arm = 1;
        4'd4: if ((m_wel || arm_old) && (wp || !m_lock)) begin
                m_bp = d[4:2]; m_lock = d[7]; ok = 1;
              end
        4'd6, 4'd7, 4'd8: if (m_wel && !guarded(m_bp, a)) begin ok = 1; e_start = 1; end
        4'd9: if (m_wel && m_bp == 0) begin ok = 1; e_start = 1; end
        default: ;
      endcase
      if (e_start) begin e_op = op; e_addr = align(op, a); end
      if (ok) begin m_busy = 1; m_cnt = dur(op) - 1; end
    end
  endtask

  task automatic step(string tag, logic v, logic [3:0] op, logic [AW-1:0] a,
                      logic [7:0] d, logic wp);
    bit bad;
    cmd_valid = v; cmd_op = op; cmd_addr = a; cmd_wdata = d; write_prot_n = wp;
    model_step(v, op, a, d, wp);
    @(negedge clk);
    cmd_valid = 0;
    checks++;
    bad = (status_o !== m_status()) || (busy_o !== m_busy) ||
          (rd_valid_o !== e_rdv) || (start_o !== e_start) ||
          (e_rdv && rd_data_o !== e_rd) ||
          (e_start && (start_op_o !== e_op || start_addr_o !== e_addr));
    if (bad) begin
      fails++;
      $display("FAIL %s: status=%h busy=%b rdv=%b rd=%h st=%b op=%h ad=%h | exp status=%h busy=%b rdv=%b rd=%h st=%b op=%h ad=%h",
        tag, status_o, busy_o, rd_valid_o, rd_data_o, start_o, start_op_o, start_addr_o,
        m_status(), m_busy, e_rdv, e_rd, e_start, e_op, e_addr);
    end
  endtask

  task automatic cmd(string tag, logic [3:0] op, logic [AW-1:0] a = '0,
                     logic [7:0] d = '0, logic wp = 1);
    step(tag, 1'b1, op, a, d, wp);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, 1'b0, 4'd0, '0, '0, 1'b1);
  endtask

  task automatic expect_sr(string tag, logic [7:0] exp);
    checks++;
    if (status_o !== exp) begin
      fails++;
      $display("FAIL %s: status=%h expected %h", tag, status_o, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    idle("R1", 2);
    expect_sr("R1", 8'h1C);
    idle("R12", 1);
    cmd("R5", 4'd6, 22'h000100);
    cmd("R2", 4'd1);
    expect_sr("R2", 8'h1E);
    cmd("R6", 4'd6, 22'h3F0000);
    cmd("R4", 4'd4, '0, 8'h00);
    cmd("R9", 4'd1);
    cmd("R10", 4'd5);
    idle("R8", 4);
    expect_sr("R8", 8'h00);
    cmd("R3", 4'd3);
    cmd("R3", 4'd4, '0, 8'h84);
    idle("R3", 5);
    expect_sr("R3", 8'h84);
    cmd("R2", 4'd1);
    cmd("R6", 4'd6, 22'h3F0010);
    cmd("R11", 4'd6, 22'h3E0123);
    idle("R8", 7);
    cmd("R2", 4'd1, '0, '0, 1'b0);
    cmd("R4", 4'd4, '0, 8'h00, 1'b0);
    expect_sr("R4", 8'h86);
    cmd("R4", 4'd4, '0, 8'h08, 1'b1);
    idle("R4", 5);
    cmd("R2", 4'd1);
    cmd("R7", 4'd9);
    expect_sr("R7", 8'h0A);
    cmd("R4", 4'd4, '0, 8'h00);
    idle("R4", 5);
    cmd("R2", 4'd1);
    cmd("R7", 4'd9);
    idle("R7", TC - 1);
    cmd("R9", 4'd1);
    expect_sr("R9", 8'h00);
    cmd("R2", 4'd1);
    cmd("R11", 4'd7, 22'h123ABC);
    idle("R11", TS + 1);
    cmd("R2", 4'd1);
    cmd("R11", 4'd8, 22'h2A5555);
    idle("R11", TB + 1);
    cmd("R3", 4'd3);
    cmd("R10", 4'd5);
    cmd("R3", 4'd4, '0, 8'h1C);
    expect_sr("R3", 8'h00);
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] op;
      op = ($urandom_range(0, 3) == 0) ? 4'd1 : 4'($urandom_range(0, 11));
      step("R6 random", ($urandom_range(0, 4) != 0), op,
           AW'($urandom()), 8'($urandom()), ($urandom_range(0, 4) != 0));
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule